// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block converts bytes from a host into an asynchronous serial bit stream. The host writes a byte into a one-entry holding register. When the frame engine is free, it moves that byte into a shift register and sends a frame. The frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional even or odd parity bit, then high stop bits. The stop time can be one bit, one and a half bits or two bits.

All bit timing comes from a single-cycle enable `tick16`, which pulses sixteen times per bit period. The block does not generate this enable. The line format is set by static inputs. The block captures them when each frame begins, so the host may reprogram them while a frame is on the line.

A byte that is already held when a frame ends starts immediately, with no idle time between the two frames. Three outputs report progress to the host:
- `tx_ready_n` rises on a write and falls when that byte's start bit appears on the line.
- `hold_empty` reports whether the holding register is free.
- `tx_empty` reports that the transmitter has gone fully quiet.

Top module: `sertx_core`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1, `tx_empty` is 1 and `tx_ready_n` is 0.
- R2: A frame begins with a start bit at 0 that lasts 16 ticks. The data bits follow least significant bit first, each lasting 16 ticks.
- R3: The character length is set by `len_sel`: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Higher data bits of the byte are not sent.
- R4: With `par_en`=1, one parity bit of 16 ticks follows the data. With `par_even`=1 the number of ones in the sent data bits plus the parity bit is even; with `par_even`=0 it is odd. With `par_en`=0 no parity bit is sent.
- R5: The stop time is at level 1. It lasts 16 ticks when `stop_ext`=0. When `stop_ext`=1 it lasts 24 ticks if `len_sel`=0 and 32 ticks for any other length.
- R6: A write (`wr_en`=1 at a clock edge) makes `tx_ready_n` 1 after that edge. `tx_ready_n` returns to 0 at the same edge where `txd` drops for that byte's start bit.
- R7: `hold_empty` is 0 while a byte waits in the holding register. `tx_empty` is 1 only when no byte is held and no frame is in progress.
- R8: If a byte is held when the last stop tick of a frame occurs, its start bit begins at that same edge, with no idle time.
- R9: The line format inputs are captured when a frame begins. Changing them during a frame does not affect that frame.
- R10: A write while a byte is already held replaces it. The last byte written is the one sent.
- R11: Bit timing advances only on `tick16` cycles. While `tick16` is 0 during a frame, `txd` holds its level.
- R12: A byte written while the transmitter is idle starts its start bit one clock after the write edge, without waiting for a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling enable, sixteen pulses per bit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| len_sel | input | 2 | Character length code (5 + code bits) |
| stop_ext | input | 1 | Extended stop time select |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | Even parity when 1, odd when 0 |
| txd | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding register is free |
| tx_empty | output | 1 | Nothing held and no frame in progress |
| tx_ready_n | output | 1 | Write handshake, high while a written byte waits |

## Verification
A bit counter or phase counter that is off by one makes a bit at the wrong tick offset. A reference sampler that reads the line at mid-bit positions catches this within the affected frame. A wrong stop-length choice, or a lost or added bit, moves the start edge of a back-to-back follow-up frame. That error shows up at the exact tick count where the next frame should begin. Handshake errors and holding-register errors show up at the ports in the first or second clock after a write: a missing `tx_ready_n` rise, a missing start edge, or the wrong byte decoded.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_START,
    FS_DATA,
    FS_PAR,
    FS_STOP
  } fstate_t;

  typedef struct packed {
    logic [1:0] len;
    logic       stop_ext;
    logic       par_en;
    logic       par_even;
  } lcfg_t;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;

  // A write in the same cycle as a take refills the register.
  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (take) full_d = 1'b0;
    if (wr_en) begin
      full_d = 1'b1;
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign full = full_q;
  assign data = data_q;

  // R10: a write always leaves the register holding the written byte
  a_r10_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (full_q && data_q == $past(wr_data)));

  // R6: a take without a write frees the register
  a_r6_take_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_en) |=> !full_q);

endmodule

// File: rtl/sertx_parity.sv
module sertx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        len,
  input  logic              even,
  output logic              pbit
);

  localparam int MIN_LEN = DATA_W - 3;

  logic [DATA_W-1:0] keep;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < MIN_LEN) begin : g_fixed
      assign keep[i] = 1'b1;
    end else begin : g_opt
      assign keep[i] = ({1'b0, len} >= 3'(i - MIN_LEN + 1));
    end
  end

  logic ones_odd;
  assign ones_odd = ^(data & keep);
  assign pbit     = even ? ones_odd : ~ones_odd;

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  lcfg_t             cfg_in,
  output logic              take,
  output logic              busy,
  output logic              txd
);

  localparam int MIN_LEN = DATA_W - 3;
  localparam int CNT_W   = $clog2(2 * OVS + 1);
  localparam int IDX_W   = $clog2(DATA_W);

  fstate_t           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  lcfg_t             cfg_q, cfg_d;
  logic              par_q, par_d;
  logic              txd_q, txd_d;

  logic              par_new;
  logic              load;
  logic              last;
  logic [CNT_W-1:0]  stop_len;
  logic [CNT_W-1:0]  dur;
  logic [IDX_W-1:0]  idx_end;

  // Parity is taken from the byte and format being loaded.
  sertx_parity #(.DATA_W(DATA_W)) u_par (
    .data (hold_data),
    .len  (cfg_in.len),
    .even (cfg_in.par_even),
    .pbit (par_new)
  );

  always_comb begin
    if (!cfg_q.stop_ext)       stop_len = CNT_W'(OVS);
    else if (cfg_q.len == 2'd0) stop_len = CNT_W'(OVS + OVS / 2);
    else                       stop_len = CNT_W'(2 * OVS);
    dur     = (st_q == FS_STOP) ? stop_len : CNT_W'(OVS);
    idx_end = IDX_W'(MIN_LEN - 1) + IDX_W'(cfg_q.len);
    last    = tick && (cnt_q == dur - CNT_W'(1));
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    cfg_d = cfg_q;
    par_d = par_q;
    load  = 1'b0;
    if (st_q != FS_IDLE && tick) cnt_d = last ? '0 : cnt_q + CNT_W'(1);
    unique case (st_q)
      FS_IDLE:  if (hold_full) load = 1'b1;
      FS_START: if (last) begin
        st_d  = FS_DATA;
        idx_d = '0;
      end
      FS_DATA:  if (last) begin
        sh_d = sh_q >> 1;
        if (idx_q == idx_end) st_d = cfg_q.par_en ? FS_PAR : FS_STOP;
        else                  idx_d = idx_q + IDX_W'(1);
      end
      FS_PAR:   if (last) st_d = FS_STOP;
      FS_STOP:  if (last) begin
        if (hold_full) load = 1'b1;
        else           st_d = FS_IDLE;
      end
      default:  st_d = FS_IDLE;
    endcase
    if (load) begin
      st_d  = FS_START;
      cnt_d = '0;
      sh_d  = hold_data;
      cfg_d = cfg_in;
      par_d = par_new;
    end
    unique case (st_d)
      FS_START: txd_d = 1'b0;
      FS_DATA:  txd_d = sh_d[0];
      FS_PAR:   txd_d = par_d;
      default:  txd_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FS_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      cfg_q <= '0;
      par_q <= 1'b0;
      txd_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      cfg_q <= cfg_d;
      par_q <= par_d;
      txd_q <= txd_d;
    end
  end

  assign take = load;
  assign busy = (st_q != FS_IDLE);
  assign txd  = txd_q;

  // R11: no tick, no movement on the line
  a_r11_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && st_q != FS_IDLE) |=> $stable(txd_q));

  // R2: the start phase drives the line low
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_START) |-> !txd_q);

  // R1: the idle line is high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_IDLE) |-> txd_q);

  // R3: the data bit index never passes the programmed length
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_DATA) |-> (idx_q <= idx_end));

  // R5: the phase counter stays inside the current phase
  a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != FS_IDLE) |-> (cnt_q < dur));

endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        len_sel,
  input  logic              stop_ext,
  input  logic              par_en,
  input  logic              par_even,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_empty,
  output logic              tx_ready_n
);

  lcfg_t             cfg;
  logic              take;
  logic              full;
  logic              busy;
  logic [DATA_W-1:0] hdata;

  always_comb begin
    cfg.len      = len_sel;
    cfg.stop_ext = stop_ext;
    cfg.par_en   = par_en;
    cfg.par_even = par_even;
  end

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .full    (full),
    .data    (hdata)
  );

  sertx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .hold_full (full),
    .hold_data (hdata),
    .cfg_in    (cfg),
    .take      (take),
    .busy      (busy),
    .txd       (txd)
  );

  assign hold_empty = !full;
  assign tx_ready_n = full;
  assign tx_empty   = !full && !busy;

  // R6: a write raises the handshake on the next edge
  a_r6_ready_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tx_ready_n);

  // R6: the handshake falls only together with a start edge
  a_r6_release_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready_n) |-> !txd);

  // R7: a quiet transmitter has nothing held
  a_r7_empty_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (hold_empty && txd));

endmodule

// File: tb/sertx_core_bench.sv
module sertx_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;

  logic       clk;
  logic       rst_n;
  logic       tick16;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [1:0] len_sel;
  logic       stop_ext;
  logic       par_en;
  logic       par_even;
  logic       txd;
  logic       hold_empty;
  logic       tx_empty;
  logic       tx_ready_n;

  sertx_core u_sertx_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick16     (tick16),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .len_sel    (len_sel),
    .stop_ext   (stop_ext),
    .par_en     (par_en),
    .par_even   (par_even),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty),
    .tx_ready_n (tx_ready_n)
  );

  typedef struct {
    logic [7:0] d;
    logic [1:0] len;
    logic       ext;
    logic       pen;
    logic       pev;
    logic       gapless;
  } item_t;

  item_t expq[$];
  int    vectors     = 0;
  int    miscompares = 0;
  int    tickcnt     = 0;
  bit    tick_on     = 1'b1;
  bit    in_frame    = 1'b0;
  bit    finished    = 1'b0;
  int    divcnt      = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Tick enable changes at the falling edge, stable at the rising edge.
  always @(negedge clk) begin
    divcnt = (divcnt == TICK_DIV - 1) ? 0 : divcnt + 1;
    tick16 = tick_on && (divcnt == 0);
  end

  always @(posedge clk) if (tick16) tickcnt <= tickcnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic e, input logic pe, input logic pv);
    @(negedge clk);
    len_sel = l; stop_ext = e; par_en = pe; par_even = pv;
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic gl);
    item_t it;
    it.d = d; it.len = len_sel; it.ext = stop_ext;
    it.pen = par_en; it.pev = par_even; it.gapless = gl;
    expq.push_back(it);
  endtask

  task automatic drain();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while ((!tx_empty || in_frame) && guard < 5000);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_ready_low();
    while (tx_ready_n) @(negedge clk);
  endtask

  // Monitor: reference sampler at mid-bit, scoreboard against the queue.
  initial begin
    item_t it;
    bit    prev = 1'b1;
    int    t0 = 0, rel, total = 0, ns = 0, si = 0, n, pb;
    int    srel[16];
    bit    sval[16];
    string stag[16];
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev = 1'b1; in_frame = 1'b0;
        continue;
      end
      if (in_frame) begin
        rel = tickcnt - t0;
        if (si < ns && rel == srel[si]) begin
          check(txd == sval[si], stag[si], "bit sampled at tick offset", txd, sval[si]);
          si++;
        end
        if (rel == total) begin
          check(si == ns, "R2", "all bit positions sampled", si, ns);
          if (it.gapless) begin
            check(txd == 1'b0, "R8", "back-to-back start at stop end", txd, 0);
            in_frame = 1'b0;
            prev = 1'b1;
          end else begin
            check(txd == 1'b1, "R5", "line high after stop time", txd, 1);
            in_frame = 1'b0;
          end
        end
      end
      if (!in_frame && prev && !txd) begin
        if (expq.size() == 0) begin
          check(1'b0, "R2", "unexpected frame start", 1, 0);
        end else begin
          it = expq.pop_front();
          in_frame = 1'b1; t0 = tickcnt; si = 0; ns = 0;
          n = 5 + it.len;
          pb = it.pen ? 1 : 0;
          srel[ns] = 8; sval[ns] = 1'b0; stag[ns] = "R2"; ns++;
          for (int i = 0; i < n; i++) begin
            srel[ns] = 16 * (1 + i) + 8; sval[ns] = it.d[i]; stag[ns] = "R3"; ns++;
          end
          if (it.pen) begin
            srel[ns] = 16 * (1 + n) + 8;
            sval[ns] = it.pev ? ^(it.d & 8'((1 << n) - 1)) : ~^(it.d & 8'((1 << n) - 1));
            stag[ns] = "R4"; ns++;
          end
          srel[ns] = 16 * (1 + n + pb) + 8; sval[ns] = 1'b1; stag[ns] = "R5"; ns++;
          if (it.ext) begin
            srel[ns] = 16 * (1 + n + pb) + 20; sval[ns] = 1'b1; stag[ns] = "R5"; ns++;
          end
          total = 16 * (1 + n + pb) + (!it.ext ? 16 : (it.len == 2'd0 ? 24 : 32));
        end
      end
      prev = txd;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic prev_txd;
    bit   moved;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    len_sel = 2'd3; stop_ext = 1'b0; par_en = 1'b0; par_even = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(txd == 1'b1, "R1", "txd after reset", txd, 1);
    check(hold_empty == 1'b1, "R1", "hold_empty after reset", hold_empty, 1);
    check(tx_empty == 1'b1, "R1", "tx_empty after reset", tx_empty, 1);
    check(tx_ready_n == 1'b0, "R1", "tx_ready_n after reset", tx_ready_n, 0);

    // R6, R12: handshake around a write to an idle transmitter
    push(8'hA5, 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hA5;
    @(negedge clk);
    wr_en = 1'b0;
    check(tx_ready_n == 1'b1, "R6", "ready_n raised after write", tx_ready_n, 1);
    check(hold_empty == 1'b0, "R7", "hold_empty low while held", hold_empty, 0);
    @(negedge clk);
    check(tx_ready_n == 1'b0, "R6", "ready_n released at start", tx_ready_n, 0);
    check(txd == 1'b0, "R12", "start bit one clock after write", txd, 0);
    check(tx_empty == 1'b0, "R7", "tx_empty low during frame", tx_empty, 0);
    drain();

    // R3, R4, R5, R8: every format, each as a gapless pair
    for (int l = 0; l < 4; l++) begin
      for (int e = 0; e < 2; e++) begin
        for (int p = 0; p < 3; p++) begin
          set_cfg(2'(l), 1'(e), p != 0, p == 2);
          push(8'(8'h35 + 8'(l * 37 + e * 11 + p * 5)), 1'b1);
          write_byte(8'(8'h35 + 8'(l * 37 + e * 11 + p * 5)));
          wait_ready_low();
          push(8'(8'hCA ^ 8'(l * 19 + e * 7 + p * 3)), 1'b0);
          write_byte(8'(8'hCA ^ 8'(l * 19 + e * 7 + p * 3)));
          check(tx_empty == 1'b0 && hold_empty == 1'b0, "R7", "status with byte held",
                {tx_empty, hold_empty}, 0);
          drain();
          check(tx_empty == 1'b1 && hold_empty == 1'b1, "R7", "status after drain",
                {tx_empty, hold_empty}, 3);
        end
      end
    end

    // R9: format change mid-frame has no effect on that frame
    set_cfg(2'd3, 1'b0, 1'b1, 1'b1);
    push(8'h3C, 1'b0);
    write_byte(8'h3C);
    repeat (40) @(negedge clk);
    len_sel = 2'd0; stop_ext = 1'b1; par_en = 1'b1; par_even = 1'b0;
    drain();

    // R10: second write while held replaces the held byte
    set_cfg(2'd3, 1'b1, 1'b0, 1'b0);
    push(8'h11, 1'b1);
    write_byte(8'h11);
    wait_ready_low();
    write_byte(8'h22);
    push(8'h9E, 1'b0);
    write_byte(8'h9E);
    drain();

    // R11: with ticks stopped the line holds its level
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    push(8'h5A, 1'b0);
    write_byte(8'h5A);
    repeat (70) @(negedge clk);
    tick_on = 1'b0;
    @(negedge clk);
    prev_txd = txd; moved = 1'b0;
    repeat (30) begin
      @(negedge clk);
      if (txd != prev_txd) moved = 1'b1;
    end
    check(!moved, "R11", "line static without ticks", moved, 0);
    tick_on = 1'b1;
    drain();

    check(expq.size() == 0, "R2", "all expected frames observed", expq.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule